// File: doc/BRIEF.md
# Four-Channel Low-Side Switch Protection Sequencer

This block is the digital control and protection logic for a four-channel low-side switch driver. Each of four parallel command inputs drives its own gate-enable output directly. The outputs are gated by an active-low enable, an active-high reset, an over-temperature flag, an undervoltage flag and a per-channel overcurrent latch. Analog comparators supply all the fault flags. The gate drivers and the current limiting are outside the block.

An overcurrent flag must stay high for a deglitch window before its channel is latched off. The channel then stays off for a fixed retry interval and afterwards follows its command again on its own. Over-temperature forces every output off until the flag drops, with no timer. Undervoltage forces every output off and also clears all overcurrent state. An active-low fault output reports any latched channel and any global fault. Both windows are parameters counted in clock cycles.

Top module: `lsd_fault_seq`

## Requirements
- R1: With `rstIn`, `enableN`, `otFlag` and `uvFlag` all low and no channel latched, `gateEn[i]` equals `chanIn[i]` in the same cycle for every one of the 16 command patterns, and `faultN` is 1.
- R2: While `enableN` is 1, every bit of `gateEn` is 0. The enable has no effect on `faultN`.
- R3: While `rstIn` is 1, `gateEn` is 0 and `faultN` is 1, and every other input is ignored. An overcurrent flag held high through reset leaves no latched channel once reset is released.
- R4: When `ocFlag[i]` is sampled high on DG_CYCLES consecutive rising edges, channel i is latched off from that last edge onward and `faultN` goes to 0.
- R5: When `ocFlag[i]` drops before DG_CYCLES consecutive high samples, the deglitch count restarts from zero. A pulse of DG_CYCLES-1 samples never latches the channel, however often it repeats.
- R6: A latched channel stays off for exactly RETRY_CYCLES clock cycles, counted from the latching edge, and then follows `chanIn[i]` again. If the flag is still high, the channel re-latches DG_CYCLES cycles after its release.
- R7: A latch on one channel does not change the gate enables of the other channels.
- R8: One rising edge with `rstIn` high clears a running retry, so the channel follows its command as soon as reset is released.
- R9: While `otFlag` is 1, `gateEn` is 0 and `faultN` is 0. When the flag drops, the outputs return in the same cycle, and any running retry keeps counting.
- R10: While `uvFlag` is 1, `gateEn` is 0 and `faultN` is 0. Every edge with the flag high clears all latched channels and all deglitch counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every window is counted in its cycles |
| rstIn | input | 1 | Active-high reset; clears all state and masks every input |
| enableN | input | 1 | Active-low output enable |
| chanIn | input | NUM_CH | Per-channel switch command, 1 = on |
| ocFlag | input | NUM_CH | Per-channel overcurrent comparator flag |
| otFlag | input | 1 | Die over-temperature flag |
| uvFlag | input | 1 | Supply undervoltage flag |
| gateEn | output | NUM_CH | Per-channel gate enable to the low-side switch |
| faultN | output | 1 | Active-low fault indication |

## Verification
The hardest case to reach from the ports is an undervoltage pulse that arrives partway through a deglitch window. The deglitch count is internal, so it can only be observed through the latch delay that follows. The bench holds the overcurrent flag high for DG_CYCLES-1 edges, pulses the undervoltage flag for one edge and keeps the flag high. It then confirms that the channel latches only after a further full DG_CYCLES edges, not after one more edge. The retry window is measured the same way, by counting how many samples the gate output stays low, and this is done both with the flag removed and with the flag held high.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Strobes from the control module to the channel datapath
  typedef struct packed {
    logic clearState;    // synchronous clear of every channel's counters and latch
    logic killOutputs;   // force every gate enable low
    logic globalFault;   // a chip-wide fault is present
    logic reportLatched; // latched channels may show on the fault output
  } lsdStrobe_t;

endpackage

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
(
  input  logic       clk,
  input  logic       rstIn,
  input  logic       enableN,
  input  logic       otFlag,
  input  logic       uvFlag,
  output lsdStrobe_t strobe
);

  always_comb begin
    strobe.clearState    = rstIn | uvFlag;
    strobe.killOutputs   = rstIn | uvFlag | otFlag | enableN;
    strobe.globalFault   = ~rstIn & (uvFlag | otFlag);
    strobe.reportLatched = ~rstIn;
  end

  // Reset masks every global condition from the fault report
  AST_RESET_MASKS_GLOBAL: assert property (@(posedge clk)
    rstIn |-> !strobe.globalFault); // R3

  // Undervoltage always clears state and silences the outputs
  AST_UV_CLEARS_AND_KILLS: assert property (@(posedge clk) disable iff (rstIn)
    uvFlag |-> (strobe.clearState && strobe.killOutputs)); // R10

endmodule

// File: rtl/lsd_oc_chan.sv
module lsd_oc_chan #(
  parameter int DG_CYCLES    = 438,
  parameter int RETRY_CYCLES = 150000
) (
  input  logic clk,
  input  logic clearState,
  input  logic ocFlag,
  output logic tripped
);

  localparam int DGW = $clog2(DG_CYCLES + 1);
  localparam int RTW = $clog2(RETRY_CYCLES + 1);
  localparam logic [DGW-1:0] DG_LAST = DGW'(DG_CYCLES - 1);
  localparam logic [RTW-1:0] RT_LAST = RTW'(RETRY_CYCLES - 1);

  logic [DGW-1:0] dgCnt;
  logic [RTW-1:0] retryCnt;

  always_ff @(posedge clk) begin
    if (clearState) begin
      dgCnt    <= '0;
      retryCnt <= '0;
      tripped  <= 1'b0;
    end else if (tripped) begin
      dgCnt <= '0;
      if (retryCnt == RT_LAST) begin
        tripped  <= 1'b0;
        retryCnt <= '0;
      end else begin
        retryCnt <= retryCnt + 1'b1;
      end
    end else if (ocFlag) begin
      if (dgCnt == DG_LAST) begin
        tripped  <= 1'b1;
        dgCnt    <= '0;
        retryCnt <= '0;
      end else begin
        dgCnt <= dgCnt + 1'b1;
      end
    end else begin
      dgCnt <= '0;
    end
  end

  AST_DG_IN_RANGE: assert property (@(posedge clk) disable iff (clearState)
    dgCnt < DGW'(DG_CYCLES)); // R5

  AST_RETRY_IN_RANGE: assert property (@(posedge clk) disable iff (clearState)
    retryCnt < RTW'(RETRY_CYCLES)); // R6

  AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (clearState)
    $rose(tripped) |-> $past(ocFlag)); // R4

endmodule

// File: rtl/lsd_datapath.sv
module lsd_datapath
  import lsd_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int DG_CYCLES    = 438,
  parameter int RETRY_CYCLES = 150000
) (
  input  logic              clk,
  input  lsdStrobe_t        strobe,
  input  logic [NUM_CH-1:0] chanIn,
  input  logic [NUM_CH-1:0] ocFlag,
  output logic [NUM_CH-1:0] gateEn,
  output logic              faultN
);

  logic [NUM_CH-1:0] tripVec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    lsd_oc_chan #(
      .DG_CYCLES   (DG_CYCLES),
      .RETRY_CYCLES(RETRY_CYCLES)
    ) uChan (
      .clk       (clk),
      .clearState(strobe.clearState),
      .ocFlag    (ocFlag[ch]),
      .tripped   (tripVec[ch])
    );
  end

  always_comb begin
    gateEn = strobe.killOutputs ? '0 : (chanIn & ~tripVec);
    faultN = ~(strobe.globalFault | (strobe.reportLatched & (|tripVec)));
  end

endmodule

// File: rtl/lsd_fault_seq.sv
module lsd_fault_seq
  import lsd_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int DG_CYCLES    = 438,
  parameter int RETRY_CYCLES = 150000
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic              enableN,
  input  logic [NUM_CH-1:0] chanIn,
  input  logic [NUM_CH-1:0] ocFlag,
  input  logic              otFlag,
  input  logic              uvFlag,
  output logic [NUM_CH-1:0] gateEn,
  output logic              faultN
);

  lsdStrobe_t strobe;

  lsd_ctrl uCtrl (
    .clk    (clk),
    .rstIn  (rstIn),
    .enableN(enableN),
    .otFlag (otFlag),
    .uvFlag (uvFlag),
    .strobe (strobe)
  );

  lsd_datapath #(
    .NUM_CH      (NUM_CH),
    .DG_CYCLES   (DG_CYCLES),
    .RETRY_CYCLES(RETRY_CYCLES)
  ) uData (
    .clk   (clk),
    .strobe(strobe),
    .chanIn(chanIn),
    .ocFlag(ocFlag),
    .gateEn(gateEn),
    .faultN(faultN)
  );

  AST_RESET_ALL_OFF: assert property (@(posedge clk)
    rstIn |-> (gateEn == '0 && faultN)); // R3

  AST_OUTPUT_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rstIn)
    (gateEn & ~chanIn) == '0); // R1

  AST_DISABLE_ALL_OFF: assert property (@(posedge clk) disable iff (rstIn)
    enableN |-> gateEn == '0); // R2

  AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (rstIn)
    otFlag |-> (gateEn == '0 && !faultN)); // R9

  AST_UV_LEAVES_NO_LATCH: assert property (@(posedge clk) disable iff (rstIn)
    ($past(uvFlag) && !uvFlag && !otFlag) |-> faultN); // R10

  AST_SUPPRESSED_REPORTS: assert property (@(posedge clk) disable iff (rstIn)
    (!enableN && !otFlag && !uvFlag && ((chanIn & ~gateEn) != '0)) |-> !faultN); // R4

endmodule

// File: tb/lsd_fault_seq_test.sv
`timescale 1ns/1ps
module lsd_fault_seq_test;

  localparam int NCH = 4;
  localparam int DG  = 4;
  localparam int RT  = 10;

  logic clk = 1'b0;
  logic rstIn = 1'b1, enableN = 1'b0, otFlag = 1'b0, uvFlag = 1'b0;
  logic [NCH-1:0] chanIn = '0, ocFlag = '0;
  logic [NCH-1:0] gateEn;
  logic faultN;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsd_fault_seq #(.NUM_CH(NCH), .DG_CYCLES(DG), .RETRY_CYCLES(RT)) uut (
    .clk(clk), .rstIn(rstIn), .enableN(enableN), .chanIn(chanIn),
    .ocFlag(ocFlag), .otFlag(otFlag), .uvFlag(uvFlag),
    .gateEn(gateEn), .faultN(faultN)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiesce();
    ocFlag = '0;
    repeat (RT + DG + 2) tick();
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int offCnt;
    int onCnt;
    bit anyOff;

    // R3: reset ignores every input
    chanIn = '1; ocFlag = '1; otFlag = 1'b1;
    repeat (2 * DG) tick();
    chk("R3 gates off in reset", gateEn, 0);
    chk("R3 fault high in reset", faultN, 1);
    otFlag = 1'b0; ocFlag = '0; rstIn = 1'b0; settle();
    chk("R3 no latch left after reset", gateEn, 4'hF);
    chk("R3 fault clear after reset", faultN, 1);

    // R1 / R2: full command sweep
    for (int p = 0; p < 16; p++) begin
      chanIn = p[3:0]; enableN = 1'b0; settle();
      chk("R1 gate follows command", gateEn, p);
      chk("R1 fault high", faultN, 1);
      enableN = 1'b1; settle();
      chk("R2 disable forces off", gateEn, 0);
      chk("R2 disable leaves fault", faultN, 1);
    end
    enableN = 1'b0; chanIn = '1; tick();

    // R4 / R5 / R6 / R7: every channel, every pulse length up to DG
    for (int ch = 0; ch < NCH; ch++) begin
      for (int len = 1; len <= DG; len++) begin
        ocFlag[ch] = 1'b1;
        for (int k = 1; k <= len; k++) begin
          tick();
          if (k < DG) chk("R5 short pulse no latch", gateEn, 4'hF);
        end
        ocFlag[ch] = 1'b0;
        settle();
        if (len == DG) begin
          chk("R4 latched channel off", gateEn[ch], 0);
          chk("R4 fault low", faultN, 0);
          chk("R7 others still on", gateEn | (4'b1 << ch), 4'hF);
          offCnt = 1;
          for (int n = 0; n < RT + 5; n++) begin
            tick();
            if (gateEn[ch] == 1'b0) offCnt++;
            else break;
          end
          chk("R6 retry length", offCnt, RT);
          chk("R6 fault clears after retry", faultN, 1);
        end
        tick();
      end
    end

    // R5: repeated short pulses never latch
    anyOff = 1'b0;
    for (int r = 0; r < 6; r++) begin
      ocFlag[0] = 1'b1;
      repeat (DG - 1) begin tick(); if (gateEn != 4'hF) anyOff = 1'b1; end
      ocFlag[0] = 1'b0;
      tick(); if (gateEn != 4'hF) anyOff = 1'b1;
    end
    chk("R5 repeated short pulses", anyOff, 0);

    // R6: persistent flag re-latches after DG on-cycles
    ocFlag[1] = 1'b1;
    repeat (DG) tick();
    chk("R4 persistent latch", gateEn, 4'hD);
    offCnt = 1;
    for (int n = 0; n < RT + 5; n++) begin
      tick();
      if (gateEn[1] == 1'b0) offCnt++;
      else break;
    end
    chk("R6 retry with flag held", offCnt, RT);
    onCnt = 1;
    for (int n = 0; n < DG + 5; n++) begin
      tick();
      if (gateEn[1] == 1'b1) onCnt++;
      else break;
    end
    chk("R6 re-latch after DG", onCnt, DG);
    quiesce();

    // R8: reset clears a running retry
    ocFlag[2] = 1'b1;
    repeat (DG) tick();
    ocFlag[2] = 1'b0;
    repeat (2) tick();
    chk("R8 latched before reset", gateEn, 4'hB);
    rstIn = 1'b1; tick(); rstIn = 1'b0; settle();
    chk("R8 reset clears latch", gateEn, 4'hF);
    chk("R8 fault clear", faultN, 1);

    // R9: thermal forces off, no timer, retry keeps counting
    ocFlag[3] = 1'b1;
    repeat (DG) tick();
    ocFlag[3] = 1'b0;
    otFlag = 1'b1; settle();
    chk("R9 thermal off", gateEn, 0);
    chk("R9 thermal fault", faultN, 0);
    repeat (2) tick();
    otFlag = 1'b0; settle();
    chk("R9 retry still running", gateEn, 4'h7);
    quiesce();
    otFlag = 1'b1;
    repeat (50) tick();
    chk("R9 long thermal off", gateEn, 0);
    otFlag = 1'b0; settle();
    chk("R9 immediate recovery", gateEn, 4'hF);
    chk("R9 fault clears", faultN, 1);

    // R10: undervoltage clears latches
    ocFlag[3] = 1'b1;
    repeat (DG) tick();
    ocFlag[3] = 1'b0;
    uvFlag = 1'b1; settle();
    chk("R10 uv off", gateEn, 0);
    chk("R10 uv fault", faultN, 0);
    tick();
    uvFlag = 1'b0; settle();
    chk("R10 latch cleared", gateEn, 4'hF);
    chk("R10 fault cleared", faultN, 1);

    // R10: undervoltage restarts the deglitch count
    ocFlag[0] = 1'b1;
    repeat (DG - 1) tick();
    uvFlag = 1'b1; tick(); uvFlag = 1'b0;
    repeat (DG - 1) tick();
    chk("R10 deglitch restarted", gateEn, 4'hF);
    tick();
    chk("R10 latch after full window", gateEn, 4'hE);
    quiesce();

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule